// File: doc/BRIEF.md
# APB Requester Transfer Controller

This block turns a simple command interface into single read or write transfers on an APB bus towards one completer. A command carries a direction bit, address, write data, byte strobes and a 3-bit protection type. The controller latches the command, runs the idle, setup and access phases, and keeps the access phase open for as long as the completer holds ready low. When the transfer completes, the read data and the error bit come back to the command side with a one-cycle done pulse.

A new command can be taken on the completing cycle of the current transfer. In that case the bus goes straight from the access phase into the setup phase of the next transfer, with no idle cycle between them. The command side sees `cmd_ready_o` high only in the idle phase or on a completing access cycle. A command offered at any other time is left waiting and has no effect on the bus.

Top module: `apb_req_ctrl`

## Requirements
- R1: Reset is active low and synchronous to the rising edge. After a clock edge with `rst_ni` low, `psel_o`, `penable_o` and `rsp_done_o` are 0 and `cmd_ready_o` is 1, even if a transfer was in progress.
- R2: `cmd_ready_o` is 1 in the idle phase, or in the access phase while `pready_i` is 1. A command is taken at a rising edge where `cmd_valid_i` and `cmd_ready_o` are both 1. The following cycle is a setup phase (`psel_o`=1, `penable_o`=0) that presents the command's address, direction, write data and protection.
- R3: A setup phase always moves to an access phase (`psel_o`=1, `penable_o`=1) at the next rising edge.
- R4: The access phase repeats for every cycle that `pready_i` is 0, with no upper limit. `paddr_o`, `pwrite_o`, `pwdata_o`, `pstrb_o` and `pprot_o` do not change from the setup phase until the transfer completes.
- R5: After an access cycle with `pready_i`=1, when no command is taken on that cycle, the bus returns to idle (`psel_o`=0, `penable_o`=0).
- R6: After an access cycle with `pready_i`=1, when a command is taken on that cycle, the next cycle is the setup phase of the new command (`psel_o`=1, `penable_o`=0) with no idle cycle in between.
- R7: `rsp_done_o` is 1 for exactly the one cycle after each completing access cycle. `rsp_err_o` then equals `pslverr_i` from the completing cycle. `rsp_rdata_o` equals `prdata_i` from that cycle for a read and is all zeros for a write. Both keep their values until the next completion.
- R8: `pstrb_o` carries the command strobes for a write (bit i enables byte i of `pwdata_o`). For a read it is all zeros.
- R9: A command offered while `cmd_ready_o` is 0 (setup phase, or an access cycle with `pready_i`=0) is not taken, and the bus request outputs keep their values.
- R10: `prdata_i` and `pslverr_i` are ignored on every cycle except the one where `psel_o`, `penable_o` and `pready_i` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Transfer address |
| cmd_wdata_i | input | DATA_W | Write data |
| cmd_strb_i | input | DATA_W/8 | Byte strobes for a write |
| cmd_prot_i | input | 3 | Protection type |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data of the last transfer |
| rsp_err_o | output | 1 | Error bit of the last transfer |
| psel_o | output | 1 | Completer select |
| penable_o | output | 1 | Access phase marker |
| pwrite_o | output | 1 | Bus direction |
| paddr_o | output | ADDR_W | Bus address |
| pwdata_o | output | DATA_W | Bus write data |
| pstrb_o | output | DATA_W/8 | Bus write strobes |
| pprot_o | output | 3 | Bus protection type |
| prdata_i | input | DATA_W | Completer read data |
| pready_i | input | 1 | Completer ready |
| pslverr_i | input | 1 | Completer error |

## Verification
Two events can fall in the same cycle: the done pulse of one transfer and the setup phase of the next. This happens whenever `cmd_valid_i` is still high on a completing access cycle. The bench provokes it by offering a second command, with a different direction and an error-flagged address, immediately after the first command is taken, and keeping it offered through the setup phase and the wait cycles. In the cycle after completion it then checks that the done pulse, the first transfer's response values, and the second transfer's setup-phase values all appear together. It also checks that the second command was refused on every earlier cycle.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;
  localparam int unsigned PROT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } bus_state_e;
endpackage

// File: rtl/apb_req_seq.sv
module apb_req_seq
  import apb_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic pready_i,
  output logic cmd_ready_o,
  output logic accept_o,
  output logic complete_o,
  output logic psel_o,
  output logic penable_o
);
  bus_state_e state_q, state_d;

  always_comb begin
    complete_o  = (state_q == ST_ACCESS) && pready_i;
    cmd_ready_o = (state_q == ST_IDLE) || complete_o;
    accept_o    = cmd_valid_i && cmd_ready_o;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (pready_i) state_d = accept_o ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign psel_o    = (state_q != ST_IDLE);
  assign penable_o = (state_q == ST_ACCESS);
endmodule

// File: rtl/apb_req_hold.sv
module apb_req_hold
  import apb_req_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic [STRB_W-1:0] cmd_strb_i,
  input  logic [PROT_W-1:0] cmd_prot_i,
  output logic              pwrite_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pwdata_o,
  output logic [STRB_W-1:0] pstrb_o,
  output logic [PROT_W-1:0] pprot_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pwrite_o <= 1'b0;
      paddr_o  <= '0;
      pwdata_o <= '0;
      pstrb_o  <= '0;
      pprot_o  <= '0;
    end else if (accept_i) begin
      pwrite_o <= cmd_write_i;
      paddr_o  <= cmd_addr_i;
      pwdata_o <= cmd_wdata_i;
      // reads carry no strobes
      pstrb_o  <= cmd_write_i ? cmd_strb_i : '0;
      pprot_o  <= cmd_prot_i;
    end
  end
endmodule

// File: rtl/apb_req_resp.sv
module apb_req_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              complete_i,
  input  logic              is_write_i,
  input  logic [DATA_W-1:0] prdata_i,
  input  logic              pslverr_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      done_o <= complete_i;
      if (complete_i) begin
        rdata_o <= is_write_i ? '0 : prdata_i;
        err_o   <= pslverr_i;
      end
    end
  end
endmodule

// File: rtl/apb_req_ctrl.sv
module apb_req_ctrl
  import apb_req_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic [STRB_W-1:0] cmd_strb_i,
  input  logic [PROT_W-1:0] cmd_prot_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              psel_o,
  output logic              penable_o,
  output logic              pwrite_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pwdata_o,
  output logic [STRB_W-1:0] pstrb_o,
  output logic [PROT_W-1:0] pprot_o,
  input  logic [DATA_W-1:0] prdata_i,
  input  logic              pready_i,
  input  logic              pslverr_i
);
  logic accept, complete;

  apb_req_seq seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .pready_i    (pready_i),
    .cmd_ready_o (cmd_ready_o),
    .accept_o    (accept),
    .complete_o  (complete),
    .psel_o      (psel_o),
    .penable_o   (penable_o)
  );

  apb_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) hold_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .cmd_write_i (cmd_write_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cmd_strb_i  (cmd_strb_i),
    .cmd_prot_i  (cmd_prot_i),
    .pwrite_o    (pwrite_o),
    .paddr_o     (paddr_o),
    .pwdata_o    (pwdata_o),
    .pstrb_o     (pstrb_o),
    .pprot_o     (pprot_o)
  );

  apb_req_resp #(.DATA_W(DATA_W)) resp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .complete_i (complete),
    .is_write_i (pwrite_o),
    .prdata_i   (prdata_i),
    .pslverr_i  (pslverr_i),
    .done_o     (rsp_done_o),
    .rdata_o    (rsp_rdata_o),
    .err_o      (rsp_err_o)
  );
endmodule

// File: rtl/apb_req_ctrl_chk.sv
module apb_req_ctrl_chk
  import apb_req_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              cmd_write_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic [DATA_W-1:0] cmd_wdata_i,
  input logic [STRB_W-1:0] cmd_strb_i,
  input logic [PROT_W-1:0] cmd_prot_i,
  input logic              rsp_done_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_err_o,
  input logic              psel_o,
  input logic              penable_o,
  input logic              pwrite_o,
  input logic [ADDR_W-1:0] paddr_o,
  input logic [DATA_W-1:0] pwdata_o,
  input logic [STRB_W-1:0] pstrb_o,
  input logic [PROT_W-1:0] pprot_o,
  input logic [DATA_W-1:0] prdata_i,
  input logic              pready_i,
  input logic              pslverr_i
);
  // R3
  enable_needs_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> psel_o);

  // R3
  setup_to_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && !penable_o) |=> (psel_o && penable_o));

  // R4
  wait_holds_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && !pready_i) |=> (psel_o && penable_o));

  // R4
  request_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && !(penable_o && pready_i)) |=>
      ($stable(paddr_o) && $stable(pwrite_o) && $stable(pwdata_o) &&
       $stable(pstrb_o) && $stable(pprot_o)));

  // R5
  enable_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && pready_i) |=> !penable_o);

  // R7
  done_after_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && pready_i) |=> rsp_done_o);

  // R7
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_o && penable_o && pready_i) |=> !rsp_done_o);

  // R8
  read_strobe_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && !pwrite_o) |-> (pstrb_o == '0));

  // R9
  ready_only_idle_or_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!psel_o || (penable_o && pready_i)));
endmodule

bind apb_req_ctrl apb_req_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/apb_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module apb_req_ctrl_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned SW = DW / 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [SW-1:0] strb;
    logic [2:0]    prot;
    logic [3:0]    waits;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0010, 32'h1122_3344, 4'hF, 3'd0, 4'd0},
    '{1'b0, 32'h0000_0010, 32'h0000_0000, 4'hF, 3'd1, 4'd0},
    '{1'b1, 32'h0000_0024, 32'hCAFE_0001, 4'h5, 3'd2, 4'd3},
    '{1'b0, 32'h0000_0124, 32'h0000_0000, 4'h0, 3'd3, 4'd1},
    '{1'b1, 32'h0000_F000, 32'h5555_AAAA, 4'h8, 3'd4, 4'd2},
    '{1'b0, 32'h0001_F008, 32'h0000_0000, 4'hC, 3'd5, 4'd4},
    '{1'b0, 32'h0000_0ABC, 32'h0000_0000, 4'h1, 3'd7, 4'd7},
    '{1'b1, 32'h0000_3FFC, 32'h0BAD_F00D, 4'h3, 3'd6, 4'd1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic          cmd_write_i = 1'b0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [DW-1:0] cmd_wdata_i = '0;
  logic [SW-1:0] cmd_strb_i = '0;
  logic [2:0]    cmd_prot_i = '0;
  logic          rsp_done_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          rsp_err_o;
  logic          psel_o, penable_o, pwrite_o;
  logic [AW-1:0] paddr_o;
  logic [DW-1:0] pwdata_o;
  logic [SW-1:0] pstrb_o;
  logic [2:0]    pprot_o;
  logic [DW-1:0] prdata_i = '0;
  logic          pready_i = 1'b0;
  logic          pslverr_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int waits_tgt = 0;
  int acc_cnt = 0;

  always #4 clk_i = ~clk_i;

  apb_req_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic model_err(input logic [AW-1:0] a);
    return a[15:12] == 4'hF;
  endfunction

  // completer: garbage data and error during wait cycles (R10)
  always @(negedge clk_i) begin
    if (psel_o && penable_o) begin
      if (acc_cnt >= waits_tgt) begin
        pready_i  = 1'b1;
        prdata_i  = model_rd(paddr_o);
        pslverr_i = model_err(paddr_o);
      end else begin
        pready_i  = 1'b0;
        prdata_i  = 32'hDEAD_BEEF;
        pslverr_i = 1'b1;
        acc_cnt   = acc_cnt + 1;
      end
    end else begin
      pready_i  = 1'b0;
      prdata_i  = 32'hFEED_FACE;
      pslverr_i = 1'b1;
      acc_cnt   = 0;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic drive_cmd(input vec_t v);
    cmd_valid_i = 1'b1;
    cmd_write_i = v.wr;
    cmd_addr_i  = v.addr;
    cmd_wdata_i = v.wdata;
    cmd_strb_i  = v.strb;
    cmd_prot_i  = v.prot;
  endtask

  task automatic scramble();
    cmd_valid_i = 1'b0;
    cmd_write_i = ~cmd_write_i;
    cmd_addr_i  = ~cmd_addr_i;
    cmd_wdata_i = ~cmd_wdata_i;
    cmd_strb_i  = ~cmd_strb_i;
    cmd_prot_i  = ~cmd_prot_i;
  endtask

  task automatic check_req(input vec_t v, input string req);
    chk(paddr_o == v.addr, req, paddr_o, v.addr);
    chk(pwrite_o == v.wr, req, pwrite_o, v.wr);
    chk(pwdata_o == v.wdata, req, pwdata_o, v.wdata);
    // R8: strobes zero on reads
    chk(pstrb_o == (v.wr ? v.strb : '0), "R8", pstrb_o, v.wr ? v.strb : '0);
    chk(pprot_o == v.prot, req, pprot_o, v.prot);
  endtask

  task automatic run_vec(input vec_t v);
    int cnt;
    logic [DW-1:0] er;
    logic ee;
    er = v.wr ? '0 : model_rd(v.addr);
    ee = model_err(v.addr);
    waits_tgt = v.waits;
    chk(cmd_ready_o == 1'b1, "R2", cmd_ready_o, 1);
    drive_cmd(v);
    step();
    scramble();
    chk(psel_o && !penable_o, "R2", {psel_o, penable_o}, 2'b10);
    check_req(v, "R2");
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      chk(psel_o && penable_o, "R3", {psel_o, penable_o}, 2'b11);
      check_req(v, "R4");
      if (pready_i) break;
      cnt++;
    end
    chk(cnt == int'(v.waits), "R4", cnt, v.waits);
    step();
    chk(!psel_o && !penable_o, "R5", {psel_o, penable_o}, 2'b00);
    chk(rsp_done_o == 1'b1, "R7", rsp_done_o, 1);
    chk(rsp_rdata_o == er, "R10", rsp_rdata_o, er);
    chk(rsp_err_o == ee, "R7", rsp_err_o, ee);
    step();
    chk(rsp_done_o == 1'b0, "R7", rsp_done_o, 0);
    chk(rsp_rdata_o == er && rsp_err_o == ee, "R7", {rsp_err_o, rsp_rdata_o}, {ee, er});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    vec_t a, b;
    repeat (3) step();
    // R1: reset state
    chk(!psel_o && !penable_o && !rsp_done_o && cmd_ready_o, "R1",
        {psel_o, penable_o, rsp_done_o, cmd_ready_o}, 4'b0001);
    rst_ni = 1'b1;
    step();

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // back-to-back, with a command refused while not ready (R6, R9)
    a = '{1'b1, 32'h0000_0200, 32'h0123_4567, 4'h6, 3'd2, 4'd2};
    b = '{1'b0, 32'h0000_F300, 32'h0, 4'hF, 3'd5, 4'd0};
    waits_tgt = a.waits;
    drive_cmd(a);
    step();
    drive_cmd(b);
    chk(cmd_ready_o == 1'b0, "R9", cmd_ready_o, 0);
    check_req(a, "R9");
    step();
    chk(cmd_ready_o == 1'b0, "R9", cmd_ready_o, 0);
    check_req(a, "R9");
    step();
    chk(cmd_ready_o == 1'b0, "R9", cmd_ready_o, 0);
    check_req(a, "R9");
    step();
    chk(pready_i && cmd_ready_o, "R2", {pready_i, cmd_ready_o}, 2'b11);
    step();
    cmd_valid_i = 1'b0;
    waits_tgt = b.waits;
    chk(psel_o && !penable_o, "R6", {psel_o, penable_o}, 2'b10);
    chk(rsp_done_o && !rsp_err_o && rsp_rdata_o == '0, "R6",
        {rsp_done_o, rsp_err_o, rsp_rdata_o}, {2'b10, 32'h0});
    check_req(b, "R6");
    step();
    chk(psel_o && penable_o && pready_i, "R3", {psel_o, penable_o, pready_i}, 3'b111);
    step();
    chk(rsp_done_o && rsp_err_o && rsp_rdata_o == model_rd(b.addr), "R7",
        {rsp_done_o, rsp_err_o, rsp_rdata_o}, {2'b11, model_rd(b.addr)});
    chk(!psel_o, "R5", psel_o, 0);

    // R1: reset in the middle of a wait
    waits_tgt = 6;
    drive_cmd(VECS[2]);
    step();
    scramble();
    step();
    step();
    rst_ni = 1'b0;
    step();
    chk(!psel_o && !penable_o && !rsp_done_o && cmd_ready_o, "R1",
        {psel_o, penable_o, rsp_done_o, cmd_ready_o}, 4'b0001);
    rst_ni = 1'b1;
    step();
    step();
    chk(!psel_o && !rsp_done_o, "R1", {psel_o, rsp_done_o}, 2'b00);
    run_vec(VECS[3]);
    summary();
  end
endmodule